// File: doc/BRIEF.md
# Programmable Audio Clock Generator

This block derives the converter clocks of a mixed-signal audio device. Two master clock pins feed a break-before-make multiplexer, and the result is the external clock. A second selection picks either that external clock or the output of an on-chip PLL as the working clock. The PLL itself is not part of this block.

Three dividers run from the working clock. Each has its own ratio code:
- a high-fidelity converter clock, dividing by 1 to 8;
- a voice converter clock, dividing by 1 to 16;
- an auxiliary ADC clock, which uses a fixed table of eight divisors, some of them odd or not a power of two.

One 16-bit configuration word holds every selection. It is loaded through a single-cycle write strobe. Two clock-doubler enables are stored in the same word and only passed out as flags, because the doubling circuit is analog and sits elsewhere.

Top module: `audio_clkgen`

## Requirements
- R1: After reset the stored word reads as 0x0002. This selects master input A, the external source, high-fidelity /1, voice /1, auxiliary /16, and both doubler flags low.
- R2: On a rising `cfg_clk` edge with `wr_en` high, `wr_data` replaces the stored word. The field layout is:
  - bit 0: 1 selects master input B;
  - bit 1: 1 selects the external clock, 0 selects the PLL;
  - bits 4:2: high-fidelity code;
  - bits 8:5: voice code;
  - bits 11:9: auxiliary code;
  - bit 12: doubler flag for input A;
  - bit 13: doubler flag for input B;
  - bits 15:14: ignored.
- R3: High-fidelity code n divides the working clock by n+1, and code 0 passes the clock through.
- R4: Voice code n divides the working clock by n+1, and code 0 passes the clock through.
- R5: Auxiliary codes 0 to 7 divide by 16, 12, 8, 6, 4, 3, 2 and 1 in that order.
- R6: For a ratio N above 1, the output is high for ceil(N/2) working-clock cycles and low for floor(N/2) cycles. Each high phase begins on a rising working-clock edge. For N = 1 the output is the working clock itself.
- R7: A new ratio code takes effect only at the end of the output period in progress. That period completes with its old length, and the next period uses the new ratio.
- R8: Word bit 1 chooses the working clock: 1 selects the external clock and 0 selects the PLL.
- R9: Word bit 0 chooses the master input. The two gates are never open together. Each gate changes only while its own clock is low, after two synchroniser stages. The external clock therefore never carries a pulse shorter than the shorter half-period of the two inputs.
- R10: `dbl_a_en` and `dbl_b_en` follow word bits 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Clock of the configuration write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 16 | Configuration word |
| mclk_a | input | 1 | Master clock input A |
| mclk_b | input | 1 | Master clock input B |
| pll_clk | input | 1 | PLL output clock |
| hifi_clk | output | 1 | High-fidelity converter clock |
| voice_clk | output | 1 | Voice converter clock |
| aux_clk | output | 1 | Auxiliary ADC clock |
| dbl_a_en | output | 1 | Doubler enable flag for input A |
| dbl_b_en | output | 1 | Doubler enable flag for input B |

## Verification
The bench builds the block with its default values: a 5-bit ratio path and two-stage synchronisers. With a 5-bit ratio path, the full /16 range of the voice and auxiliary dividers can be reached. With two-stage synchronisers, the A/B handover finishes within a few hundred nanoseconds of the write.

The three input clocks are given distinct periods of 20, 16 and 12 ns. Because of this, a measured period and high time show both the ratio and which clock was actually selected. Directed cases cover:
- every auxiliary code;
- the largest codes of the two linear dividers;
- a ratio change in the middle of a period;
- back-to-back A/B handovers while a pulse-width monitor watches the output.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;
  localparam int RW     = 5;   // ratio width, holds 1..16
  localparam int NDIV   = 3;   // number of divided outputs
  localparam int CFG_W  = 16;

  typedef struct packed {
    logic [1:0] spare;
    logic       dbl_b;
    logic       dbl_a;
    logic [2:0] aux;
    logic [3:0] voice;
    logic [2:0] hifi;
    logic       use_ext;
    logic       mux_b;
  } cfg_t;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0002;

  // Linear code: ratio is code plus one.
  function automatic logic [RW-1:0] linear_ratio(input logic [3:0] code);
    return RW'(code) + RW'(1);
  endfunction

  // Auxiliary divisor table.
  function automatic logic [RW-1:0] aux_ratio(input logic [2:0] code);
    logic [RW-1:0] r;
    case (code)
      3'd0: r = RW'(16);
      3'd1: r = RW'(12);
      3'd2: r = RW'(8);
      3'd3: r = RW'(6);
      3'd4: r = RW'(4);
      3'd5: r = RW'(3);
      3'd6: r = RW'(2);
      default: r = RW'(1);
    endcase
    return r;
  endfunction

  // High phase length in source cycles: ceil(r/2).
  function automatic logic [RW-1:0] high_len(input logic [RW-1:0] r);
    return (r >> 1) + RW'(r[0]);
  endfunction
endpackage

// File: rtl/aclk_rst_sync.sv
`timescale 1ns/1ps
module aclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/aclk_gmux.sv
`timescale 1ns/1ps
module aclk_gmux #(
  parameter int SYNC_N = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel_b,
  output logic clk_o,
  output logic en_a_o,
  output logic en_b_o
);
  logic [SYNC_N-1:0] sync_a_q, sync_b_q;
  logic en_a_q, en_b_q;
  logic req_a, req_b;

  // Each side may open only once the other gate is seen closed.
  assign req_a = ~sel_b & ~en_b_q;
  assign req_b =  sel_b & ~en_a_q;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) sync_a_q <= '1;
    else        sync_a_q <= {sync_a_q[SYNC_N-2:0], req_a};
  end

  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) en_a_q <= 1'b1;
    else        en_a_q <= sync_a_q[SYNC_N-1];
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) sync_b_q <= '0;
    else        sync_b_q <= {sync_b_q[SYNC_N-2:0], req_b};
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) en_b_q <= 1'b0;
    else        en_b_q <= sync_b_q[SYNC_N-1];
  end

  assign clk_o  = (clk_a & en_a_q) | (clk_b & en_b_q);
  assign en_a_o = en_a_q;
  assign en_b_o = en_b_q;
endmodule

// File: rtl/aclk_div.sv
`timescale 1ns/1ps
module aclk_div
  import aclk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  output logic          clk_o,
  output logic          wrap_o,
  output logic          phase_o,
  output logic [RW-1:0] cur_o,
  output logic [RW-1:0] cnt_o
);
  logic [RW-1:0] cur_q, cnt_q, cur_nx, cnt_nx;
  logic          phase_q, wrap;

  assign wrap = (cnt_q == cur_q - RW'(1));

  always_comb begin
    cur_nx = wrap ? ratio : cur_q;
    cnt_nx = wrap ? '0 : cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= RW'(1);
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cur_q   <= cur_nx;
      cnt_q   <= cnt_nx;
      phase_q <= (cnt_nx < high_len(cur_nx));
    end
  end

  assign clk_o   = (cur_q == RW'(1)) ? clk : phase_q;
  assign wrap_o  = wrap;
  assign phase_o = phase_q;
  assign cur_o   = cur_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen
  import aclk_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              mclk_a,
  input  logic              mclk_b,
  input  logic              pll_clk,
  output logic              hifi_clk,
  output logic              voice_clk,
  output logic              aux_clk,
  output logic              dbl_a_en,
  output logic              dbl_b_en
);
  cfg_t cfg_q;
  logic ext_clk, work_clk, work_rst_n;
  logic mux_en_a, mux_en_b;
  logic unused_spare;

  logic [NDIV-1:0][RW-1:0] div_ratio, div_cur, div_cnt;
  logic [NDIV-1:0]         div_wrap, div_phase, div_out;

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= cfg_t'(CFG_RESET);
    else if (wr_en) cfg_q <= cfg_t'(wr_data);
  end
  assign unused_spare = ^cfg_q.spare;

  aclk_gmux #(.SYNC_N(SYNC_N)) u_gmux (
    .clk_a (mclk_a),
    .clk_b (mclk_b),
    .rst_n (rst_n),
    .sel_b (cfg_q.mux_b),
    .clk_o (ext_clk),
    .en_a_o(mux_en_a),
    .en_b_o(mux_en_b)
  );

  assign work_clk = cfg_q.use_ext ? ext_clk : pll_clk;

  aclk_rst_sync #(.STAGES(SYNC_N)) u_work_rst (
    .clk    (work_clk),
    .arst_n (rst_n),
    .rst_n_o(work_rst_n)
  );

  assign div_ratio[0] = linear_ratio({1'b0, cfg_q.hifi});
  assign div_ratio[1] = linear_ratio(cfg_q.voice);
  assign div_ratio[2] = aux_ratio(cfg_q.aux);

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    aclk_div u_div (
      .clk    (work_clk),
      .rst_n  (work_rst_n),
      .ratio  (div_ratio[g]),
      .clk_o  (div_out[g]),
      .wrap_o (div_wrap[g]),
      .phase_o(div_phase[g]),
      .cur_o  (div_cur[g]),
      .cnt_o  (div_cnt[g])
    );
  end

  assign hifi_clk  = div_out[0];
  assign voice_clk = div_out[1];
  assign aux_clk   = div_out[2];
  assign dbl_a_en  = cfg_q.dbl_a;
  assign dbl_b_en  = cfg_q.dbl_b;
endmodule

// File: rtl/aclk_checker.sv
`timescale 1ns/1ps
module aclk_checker
  import aclk_pkg::*;
(
  input logic                    cfg_clk,
  input logic                    rst_n,
  input logic                    work_clk,
  input logic                    work_rst_n,
  input logic                    mclk_b,
  input logic                    en_a,
  input logic                    en_b,
  input logic [NDIV-1:0]         div_wrap,
  input logic [NDIV-1:0]         div_phase,
  input logic [NDIV-1:0][RW-1:0] div_cur,
  input logic [NDIV-1:0][RW-1:0] div_cnt,
  input logic [NDIV-1:0][RW-1:0] div_ratio
);
  logic [1:0] age_q;
  logic       armed;

  always_ff @(posedge work_clk or negedge work_rst_n) begin
    if (!work_rst_n)          age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end
  assign armed = (age_q == 2'd3);

  assert_no_overlap_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !(en_a && en_b));

  assert_break_before_make_R9: assert property (@(posedge mclk_b) disable iff (!rst_n)
    $rose(en_b) |-> !en_a);

  for (genvar i = 0; i < NDIV; i++) begin : g_chk
    assert_ratio_hold_R7: assert property (@(posedge work_clk) disable iff (!armed)
      !div_wrap[i] |=> $stable(div_cur[i]));

    assert_ratio_load_R7: assert property (@(posedge work_clk) disable iff (!armed)
      div_wrap[i] |=> (div_cur[i] == $past(div_ratio[i])));

    assert_count_range_R6: assert property (@(posedge work_clk) disable iff (!armed)
      div_cnt[i] < div_cur[i]);

    assert_rise_on_wrap_R6: assert property (@(posedge work_clk) disable iff (!armed)
      div_wrap[i] |=> div_phase[i]);
  end
endmodule

bind audio_clkgen aclk_checker u_chk (
  .cfg_clk   (cfg_clk),
  .rst_n     (rst_n),
  .work_clk  (work_clk),
  .work_rst_n(work_rst_n),
  .mclk_b    (mclk_b),
  .en_a      (mux_en_a),
  .en_b      (mux_en_b),
  .div_wrap  (div_wrap),
  .div_phase (div_phase),
  .div_cur   (div_cur),
  .div_cnt   (div_cnt),
  .div_ratio (div_ratio)
);

// File: tb/tb_audio_clkgen.sv
`timescale 1ns/1ps
module tb_audio_clkgen;
  localparam longint T_A = 20, T_B = 16, T_P = 12;

  logic        cfg_clk = 0, mclk_a = 0, mclk_b = 0, pll_clk = 0;
  logic        rst_n = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic        hifi_clk, voice_clk, aux_clk, dbl_a_en, dbl_b_en;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #2  cfg_clk = ~cfg_clk;   // 250 MHz
  always #10 mclk_a  = ~mclk_a;
  always #8  mclk_b  = ~mclk_b;
  always #6  pll_clk = ~pll_clk;

  audio_clkgen dut (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mclk_a(mclk_a), .mclk_b(mclk_b), .pll_clk(pll_clk),
    .hifi_clk(hifi_clk), .voice_clk(voice_clk), .aux_clk(aux_clk),
    .dbl_a_en(dbl_a_en), .dbl_b_en(dbl_b_en)
  );

  // Pulse-width monitor on the high-fidelity output.
  bit     watch = 0;
  longint last_t = 0, min_w = 1000;
  always @(hifi_clk) begin
    if (watch && ($time - last_t) < min_w) min_w = $time - last_t;
    last_t = $time;
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench restatement of the ratios.
  function automatic int exp_ratio(input int which, input logic [15:0] w);
    int aux_tab [8] = '{16, 12, 8, 6, 4, 3, 2, 1};
    case (which)
      0: return int'(w[4:2]) + 1;
      1: return int'(w[8:5]) + 1;
      default: return aux_tab[w[11:9]];
    endcase
  endfunction

  function automatic longint src_period(input logic [15:0] w);
    if (!w[1]) return T_P;
    return w[0] ? T_B : T_A;
  endfunction

  function automatic longint exp_high(input int n, input longint t);
    if (n == 1) return t / 2;
    return longint'((n + 1) / 2) * t;
  endfunction

  task automatic wait_edge(input int which, input bit rise);
    case (which)
      0: if (rise) @(posedge hifi_clk);  else @(negedge hifi_clk);
      1: if (rise) @(posedge voice_clk); else @(negedge voice_clk);
      default: if (rise) @(posedge aux_clk); else @(negedge aux_clk);
    endcase
  endtask

  task automatic measure(input int which, output longint per, output longint hi);
    longint t0, t1;
    wait_edge(which, 1'b1); t0 = $time;
    wait_edge(which, 1'b0); t1 = $time;
    wait_edge(which, 1'b1);
    per = $time - t0;
    hi  = t1 - t0;
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge cfg_clk); wr_en = 1'b1; wr_data = w;
    @(negedge cfg_clk); wr_en = 1'b0;
  endtask

  task automatic check_outputs(input string tag, input logic [15:0] w);
    longint per, hi, t;
    string  names [3] = '{"hifi", "voice", "aux"};
    string  reqs  [3] = '{"R3", "R4", "R5"};
    t = src_period(w);
    for (int i = 0; i < 3; i++) begin
      int n = exp_ratio(i, w);
      wait_edge(i, 1'b1); wait_edge(i, 1'b1);
      measure(i, per, hi);
      check({reqs[i], "/", tag}, {names[i], " period"}, per, longint'(n) * t);
      check({"R6/", tag}, {names[i], " high time"}, hi, exp_high(n, t));
    end
    check({"R10/", tag}, "dbl_a_en", longint'(dbl_a_en), longint'(w[12]));
    check({"R10/", tag}, "dbl_b_en", longint'(dbl_b_en), longint'(w[13]));
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [15:0] w;
    longint t0, t1, t2;
    void'($urandom(32'h1A2B3C4D));
    #21 rst_n = 1'b1;
    #200;
    // R1: reset state (A, external, /1, /1, /16, flags off)
    check_outputs("R1 reset", 16'h0002);

    // R8: PLL source, R2 layout
    w = 16'h0002 & ~16'h0002;           // PLL, A
    w[4:2] = 3'd7; w[8:5] = 4'd15; w[11:9] = 3'd5;
    write_cfg(w); #200;
    check_outputs("R8 pll max codes", w);

    // R5: every auxiliary code on the PLL clock
    for (int c = 0; c < 8; c++) begin
      w[11:9] = 3'(c); w[4:2] = 3'(c); w[8:5] = 4'(15 - c);
      write_cfg(w); #100;
      check_outputs("R5 aux sweep", w);
    end

    // R9: input B via external path, R2 ignored spare bits
    w = 16'hC000 | 16'h0003 | (16'd2 << 2) | (16'd5 << 5) | (16'd3 << 9);
    write_cfg(w); #400;
    check_outputs("R9 input B", w);

    // R9: glitch-free handovers watched on pass-through output
    write_cfg(16'h0003); #400;
    min_w = 1000; watch = 1;
    write_cfg(16'h0002); #400;
    write_cfg(16'h0003); #400;
    write_cfg(16'h0002); #400;
    watch = 0;
    check("R9", "shortest pulse >= 8 ns", longint'(min_w >= 8), 1);

    // R7: ratio change mid-period
    write_cfg(16'h0002); #400;          // A, external, aux /16
    @(posedge aux_clk); t0 = $time;
    #40 write_cfg(16'h0002 | (16'd7 << 9));
    @(posedge aux_clk); t1 = $time;
    @(posedge aux_clk); t2 = $time;
    check("R7", "period in progress keeps old ratio", t1 - t0, 16 * T_A);
    check("R7", "next period uses new ratio", t2 - t1, T_A);

    // Constrained random words
    for (int k = 0; k < 10; k++) begin
      w = 16'($urandom) & 16'h3FFF;
      write_cfg(w); #400;
      check_outputs("R2 random", w);
    end

    done = 1;
    report();
  end
endmodule